// File: doc/BRIEF.md
# Four-Phase Handshake Monitor

This block watches a `req`/`ack` pair that follows the four-phase return-to-zero handshake and reports, cycle by cycle, which phase the exchange is in. A legal exchange leaves the idle state (both low) when the request rises. It waits while the request is high and the acknowledge is low. It moves on when both are high, then sees the request fall while the acknowledge may still be high. It completes once both lines are low again.

Two kinds of misbehaviour are reported on separate pulse outputs. An ordering error covers a request that is withdrawn too early, a request that rises before the return to zero, and an acknowledge that falls while the request is still high. A spurious acknowledge is an acknowledge that no request caused. After any error the monitor waits for both lines to be low and then starts again from idle. A wrapping counter records each completed exchange.

Top module: `hs4_monitor`

## Requirements
- R1: While reset is asserted and after its release, `phase_o` is 0 (idle), both error outputs are low and `done_cnt_o` is 0.
- R2: For the legal order idle → request only (`req`=1, `ack`=0) → both high → request low with ack high → both low, `phase_o` shows 1, 2, 3 and 0 in turn, one cycle after each input pattern is sampled, and no error is raised. Each phase may last any number of cycles.
- R3: From the both-high phase, both lines falling in the same cycle is a legal completion: the monitor goes to idle with no error.
- R4: In idle, a sampled `ack`=1 (with `req` either 0 or 1) raises `spur_ack_o` in the next cycle, and `phase_o` becomes 4 (recovery).
- R5: In the request-only phase, sampling `req`=0 raises `order_err_o`. The next phase is 0 if `ack`=0 and 4 if `ack`=1.
- R6: An ordering error moves the monitor to phase 4 in each of these cases: in the request-low phase, `req` rises while `ack` is high or falls in the same cycle; in the both-high phase, `ack` falls while `req` stays high.
- R7: Each error output is high for exactly one cycle per offending sample, and the two never coincide. In phase 4 no error is raised, and the monitor goes to 0 one cycle after both lines are sampled low.
- R8: `done_cnt_o` increments by one, in the cycle after each legal completion (R2, R3), and wraps modulo 2^`CNT_W`. No other event changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request line, synchronous to clk_i |
| ack_i | input | 1 | Acknowledge line, synchronous to clk_i |
| phase_o | output | 3 | Phase code: 0 idle, 1 request only, 2 both high, 3 request low, 4 recovery |
| order_err_o | output | 1 | One-cycle pulse on an ordering error |
| spur_ack_o | output | 1 | One-cycle pulse on an acknowledge with no request |
| done_cnt_o | output | CNT_W | Count of completed exchanges, wrapping |

## Verification
The assertions assume that `req_i` and `ack_i` are already synchronous to `clk_i` and hold one value across each sampling edge. They also assume no X values after reset. The stimulus changes the lines only on the falling clock edge and keeps them at 0 or 1. Only the order of the samples matters: the illegal sequences are applied on purpose, and each is followed by a return to both-low so that the recovery path is covered as well.

// File: rtl/hs4_pkg.sv
package hs4_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_REQ  = 3'd1,
    PH_BOTH = 3'd2,
    PH_DROP = 3'd3,
    PH_WAIT = 3'd4
  } hs_phase_e;

  typedef struct packed {
    logic order;
    logic spur;
    logic done;
  } hs_evt_t;
endpackage

// File: rtl/hs4_phase_fsm.sv
module hs4_phase_fsm
  import hs4_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_i,
  input  logic      ack_i,
  output hs_phase_e phase_o,
  output hs_evt_t   evt_o
);
  hs_phase_e ph_q, ph_d;
  logic      both_lo;

  assign both_lo = !req_i && !ack_i;

  always_comb begin
    ph_d  = ph_q;
    evt_o = '0;
    unique case (ph_q)
      PH_IDLE: begin
        if (ack_i) begin
          evt_o.spur = 1'b1;
          ph_d       = PH_WAIT;
        end else if (req_i) begin
          ph_d = PH_REQ;
        end
      end
      PH_REQ: begin
        if (!req_i) begin
          evt_o.order = 1'b1;
          ph_d        = ack_i ? PH_WAIT : PH_IDLE;
        end else if (ack_i) begin
          ph_d = PH_BOTH;
        end
      end
      PH_BOTH: begin
        if (both_lo) begin
          evt_o.done = 1'b1;
          ph_d       = PH_IDLE;
        end else if (!req_i) begin
          ph_d = PH_DROP;
        end else if (!ack_i) begin
          evt_o.order = 1'b1;
          ph_d        = PH_WAIT;
        end
      end
      PH_DROP: begin
        if (both_lo) begin
          evt_o.done = 1'b1;
          ph_d       = PH_IDLE;
        end else if (req_i) begin
          // req back up before the return to zero
          evt_o.order = 1'b1;
          ph_d        = PH_WAIT;
        end
      end
      PH_WAIT: begin
        if (both_lo) ph_d = PH_IDLE;
      end
      default: ph_d = PH_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= PH_IDLE;
    else         ph_q <= ph_d;
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/hs4_evt_reg.sv
module hs4_evt_reg
  import hs4_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  hs_evt_t evt_i,
  output logic    order_err_o,
  output logic    spur_ack_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      order_err_o <= 1'b0;
      spur_ack_o  <= 1'b0;
    end else begin
      order_err_o <= evt_i.order;
      spur_ack_o  <= evt_i.spur;
    end
  end
endmodule

// File: rtl/hs4_done_ctr.sv
module hs4_done_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + ONE;
  end
endmodule

// File: rtl/hs4_monitor.sv
module hs4_monitor
  import hs4_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             ack_i,
  output logic [2:0]       phase_o,
  output logic             order_err_o,
  output logic             spur_ack_o,
  output logic [CNT_W-1:0] done_cnt_o
);
  hs_phase_e ph;
  hs_evt_t   evt;

  hs4_phase_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .ack_i   (ack_i),
    .phase_o (ph),
    .evt_o   (evt)
  );

  hs4_evt_reg u_evt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .evt_i       (evt),
    .order_err_o (order_err_o),
    .spur_ack_o  (spur_ack_o)
  );

  hs4_done_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (evt.done),
    .cnt_o  (done_cnt_o)
  );

  assign phase_o = ph;
endmodule

// File: rtl/hs4_monitor_chk.sv
module hs4_monitor_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             ack_i,
  input logic [2:0]       phase_o,
  input logic             order_err_o,
  input logic             spur_ack_o,
  input logic [CNT_W-1:0] done_cnt_o
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_REQ  = 3'd1;
  localparam logic [2:0] C_BOTH = 3'd2;
  localparam logic [2:0] C_WAIT = 3'd4;

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |=> (phase_o == C_IDLE && done_cnt_o == '0)); // R1

  AST_BOTH_DROP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == C_BOTH && !req_i && !ack_i) |=> (!order_err_o && !spur_ack_o && phase_o == C_IDLE)); // R3

  AST_SPUR_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == C_IDLE && ack_i) |=> (spur_ack_o && phase_o == C_WAIT)); // R4

  AST_EARLY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == C_REQ && !req_i) |=> order_err_o); // R5

  AST_ORDER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    order_err_o |=> !order_err_o); // R7

  AST_SPUR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spur_ack_o |=> !spur_ack_o); // R7

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({order_err_o, spur_ack_o})); // R7

  AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == C_WAIT && !req_i && !ack_i) |=> phase_o == C_IDLE); // R7

  AST_WAIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == C_WAIT) |=> (!order_err_o && !spur_ack_o)); // R7

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_cnt_o != $past(done_cnt_o)) |-> (done_cnt_o == $past(done_cnt_o) + CNT_W'(1))); // R8
endmodule

bind hs4_monitor hs4_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .ack_i       (ack_i),
  .phase_o     (phase_o),
  .order_err_o (order_err_o),
  .spur_ack_o  (spur_ack_o),
  .done_cnt_o  (done_cnt_o)
);

// File: tb/hs4_monitor_tb_top.sv
module hs4_monitor_tb_top;
  localparam int CLK_PER = 10;
  localparam int CW      = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          ack = 1'b0;
  logic [2:0]    phase;
  logic          oerr, serr;
  logic [CW-1:0] cnt;

  int    total = 0;
  int    bad   = 0;
  string tag   = "R1";

  // reference model state
  int m_ph = 0, m_cnt = 0;
  bit m_oerr = 0, m_serr = 0;

  always #(CLK_PER/2) clk = ~clk;

  hs4_monitor #(.CNT_W(CW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .ack_i       (ack),
    .phase_o     (phase),
    .order_err_o (oerr),
    .spur_ack_o  (serr),
    .done_cnt_o  (cnt)
  );

  // behavioural reference: phase codes 0 idle,1 req,2 both,3 drop,4 wait
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_oerr = 0; m_serr = 0;
    end else begin
      m_oerr = 0; m_serr = 0;
      if (m_ph == 0) begin
        if (ack) begin m_serr = 1; m_ph = 4; end
        else if (req) m_ph = 1;
      end else if (m_ph == 1) begin
        if (!req) begin m_oerr = 1; m_ph = (ack ? 4 : 0); end
        else if (ack) m_ph = 2;
      end else if (m_ph == 2 || m_ph == 3) begin
        if (!req && !ack) begin m_ph = 0; m_cnt = (m_cnt + 1) % (1 << CW); end
        else if (m_ph == 2 && !req) m_ph = 3;
        else if (m_ph == 2 && !ack) begin m_oerr = 1; m_ph = 4; end
        else if (m_ph == 3 && req) begin m_oerr = 1; m_ph = 4; end
      end else begin
        if (!req && !ack) m_ph = 0;
      end
    end
  end

  task automatic check(string t, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(tag, "phase", int'(phase), m_ph);
      check(tag, "order_err", int'(oerr), int'(m_oerr));
      check(tag, "spur_ack", int'(serr), int'(m_serr));
      check(tag, "count", int'(cnt), m_cnt);
    end
  end

  task automatic drive(bit r, bit a, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = r; ack = a;
    end
  endtask

  task automatic legal(int n1, int n2, int n3);
    drive(1, 0, n1);
    drive(1, 1, n2);
    drive(0, 1, n3);
    drive(0, 0, 1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset phase", int'(phase), 0);
    check("R1", "reset count", int'(cnt), 0);
    check("R1", "reset errs", int'({oerr, serr}), 0);
    rst_n = 1'b1;
    drive(0, 0, 2);

    tag = "R2"; legal(1, 1, 1); legal(3, 2, 4); legal(2, 5, 1);
    drive(0, 0, 3);
    tag = "R3"; drive(1, 0, 2); drive(1, 1, 2); drive(0, 0, 2);
    tag = "R4"; drive(0, 1, 4); drive(0, 0, 2);
    tag = "R4"; drive(1, 1, 3); drive(0, 0, 2);
    tag = "R5"; drive(1, 0, 2); drive(0, 0, 2);
    tag = "R5"; drive(1, 0, 1); drive(0, 1, 3); drive(0, 0, 2);
    tag = "R6"; drive(1, 0, 1); drive(1, 1, 1); drive(0, 1, 2); drive(1, 1, 2); drive(0, 0, 2);
    tag = "R6"; drive(1, 0, 1); drive(1, 1, 1); drive(0, 1, 1); drive(1, 0, 2); drive(0, 0, 2);
    tag = "R6"; drive(1, 0, 1); drive(1, 1, 2); drive(1, 0, 3); drive(0, 0, 2);
    tag = "R7"; drive(0, 1, 1); drive(1, 1, 1); drive(1, 0, 1); drive(0, 0, 1); drive(0, 0, 1);
    tag = "R8";
    for (int k = 0; k < 11; k++) legal(1 + k % 2, 1 + k % 3, 1);
    drive(0, 0, 3);

    @(negedge clk);
    rst_n = 1'b0; tag = "R1";
    @(negedge clk);
    check("R1", "mid reset phase", int'(phase), 0);
    check("R1", "mid reset count", int'(cnt), 0);
    rst_n = 1'b1;
    drive(0, 0, 2);
    tag = "R2"; legal(1, 1, 1); drive(0, 0, 2);
    finish_run();
  end
endmodule